// File: doc/BRIEF.md
# Priority Scheduling List Checker

This block is a passive shadow scheduler for a processor running a preemptive, priority-driven task kernel. An upstream flow classifier hands it a stream of kernel events (tick seen, interrupt line raised, interrupt handler entered, rescheduling with the task it chose, kernel list update, semaphore block, semaphore release, and plain "task N is executing" observations). From these events the block maintains its own ready set and blocked set of tasks, computes which task a correct preemptive scheduler would choose, and compares that with what the processor actually did.

Task priorities are written through a small configuration port before the monitor is started. A start pulse then seeds the ready set with every configured task plus the idle task (task 0, always priority 0), empties the blocked set and assumes the idle task is running. The first misbehaviour found latches a 4-bit error code and a sticky flag that only reset clears. Among ready tasks that share the top priority, the expected choice rotates: the search starts just after the task currently running.

The event input is a valid/ready stream. `ev_ready` is low from reset until the start pulse has been taken, and high on every cycle after that. Events offered while `ev_ready` is low are dropped. Once ready is high, the block never applies back-pressure: one event is consumed on each cycle where `ev_valid` is high.

Top module: `prio_sched_guard`

## Requirements
- R1: After reset, `err_flag` is 0, `err_code` is 0 and `ev_ready` is 0.
- R2: `ev_ready` rises on the cycle after `start` is sampled and stays high. Events offered before that are ignored and raise no error.
- R3: On start, every task that has been given a priority is ready, along with idle task 0. Nothing is blocked, and task 0 is taken as running. A RUN event (code 0) naming a ready task other than the running one reports code 3.
- R4: A SCHED event (code 4) must name the ready task of highest priority. Otherwise code 3 is reported. The named task becomes the running task.
- R5: When several ready tasks share the highest priority, the expected SCHED choice is the first of them met when counting upward, with wrap-around, from the task after the running one.
- R6: SEMBLK (code 6) moves the running task from the ready set to the blocked set, except that the idle task is never blocked. SEMWAKE (code 7) moves the named blocked task back to ready.
- R7: A RUN or SCHED naming a blocked task reports code 1. One naming a task in neither set (including unconfigured or out-of-range numbers) reports code 2.
- R8: A TICK (code 1) arriving while an earlier tick has not yet been followed by a SCHED reports code 4. A SCHED with no pending tick, block or wake reports code 5.
- R9: IRQ (code 2) while a previous IRQ has not yet been handled reports code 6. ISR (code 3) without a pending IRQ reports code 7.
- R10: A SCHED while the previous SCHED still awaits its LISTUPD (code 5) reports code 8. A LISTUPD with no SCHED awaiting one reports code 9.
- R11: The first error latches: `err_flag` and `err_code` hold until reset. When one event violates several rules, the lowest code is kept.
- R12: Task 0 always has priority 0. Configuration writes aimed at task 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Seeds the task sets and opens the event stream |
| cfg_we | input | 1 | Priority write strobe |
| cfg_task | input | 4 | Task number to configure |
| cfg_prio | input | 3 | Priority value, larger is more urgent |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted when high together with valid |
| ev_code | input | 3 | Event kind (0 RUN, 1 TICK, 2 IRQ, 3 ISR, 4 SCHED, 5 LISTUPD, 6 SEMBLK, 7 SEMWAKE) |
| ev_task | input | 4 | Task number carried by RUN, SCHED and SEMWAKE |
| err_flag | output | 1 | Sticky error indication |
| err_code | output | 4 | Code of the first error, 0 when none |

## Verification
The shadow sets are hidden, so a corrupted set or a stale running pointer only shows up when a later SCHED or RUN is checked against it. That check then returns a wrong code 1, 2 or 3, one cycle after the event that exposes the fault. A lost pending flag in the sequence tracking shows up as a missing or spurious code 4 to 9 on the next tick, interrupt or list-update event. The bench therefore drives event sequences that first build up state and then probe it, and it compares the latched code after every accepted event.

// File: rtl/sched_chk_pkg.sv
package sched_chk_pkg;

  typedef enum logic [2:0] {
    EV_RUN     = 3'd0,
    EV_TICK    = 3'd1,
    EV_IRQ     = 3'd2,
    EV_ISR     = 3'd3,
    EV_SCHED   = 3'd4,
    EV_LISTUPD = 3'd5,
    EV_SEMBLK  = 3'd6,
    EV_SEMWAKE = 3'd7
  } ev_e;

  typedef enum logic [3:0] {
    ERR_NONE       = 4'd0,
    ERR_BLK_RUNS   = 4'd1,
    ERR_UNKNOWN    = 4'd2,
    ERR_NOT_TOP    = 4'd3,
    ERR_TICK_LOST  = 4'd4,
    ERR_SCHED_BARE = 4'd5,
    ERR_IRQ_LOST   = 4'd6,
    ERR_ISR_BARE   = 4'd7,
    ERR_NO_UPDATE  = 4'd8,
    ERR_UPD_BARE   = 4'd9
  } err_e;

endpackage

// File: rtl/task_set_store.sv
// Presence store: one bit per task, searched in parallel by task number.
module task_set_store #(
  parameter int N  = 14,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  load_val,
  input  logic          set_en,
  input  logic [TW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [TW-1:0] clr_idx,
  output logic [N-1:0]  present
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                present[i] <= 1'b0;
      else if (load)                             present[i] <= load_val[i];
      else if (set_en && (set_idx == TW'(i)))    present[i] <= 1'b1;
      else if (clr_en && (clr_idx == TW'(i)))    present[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/rr_prio_picker.sv
// Highest ready priority, rotating among equals from the task after 'last'.
module rr_prio_picker #(
  parameter int N  = 14,
  parameter int TW = 4,
  parameter int PW = 3
) (
  input  logic [N-1:0]         ready,
  input  logic [N-1:0][PW-1:0] prio,
  input  logic [TW-1:0]        last,
  output logic [TW-1:0]        pick
);

  logic [PW-1:0] top_prio;
  logic [N-1:0]  cand;

  always_comb begin
    top_prio = '0;
    for (int i = 0; i < N; i++)
      if (ready[i] && (prio[i] > top_prio)) top_prio = prio[i];
  end

  for (genvar i = 0; i < N; i++) begin : g_cand
    assign cand[i] = ready[i] && (prio[i] == top_prio);
  end

  always_comb begin
    logic found;
    int   idx;
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= N; k++) begin
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (!found && cand[idx]) begin
        pick  = TW'(idx);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/kernel_seq_watch.sv
// Tracks which kernel events are owed a follow-up and flags broken pairings.
module kernel_seq_watch
  import sched_chk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic acc,
  input  ev_e  code,
  output err_e seq_err
);

  logic tick_p, sync_p, irq_p, upd_p;

  always_comb begin
    seq_err = ERR_NONE;
    if (acc) begin
      unique case (code)
        EV_TICK:    if (tick_p) seq_err = ERR_TICK_LOST;
        EV_SCHED:   if (!(tick_p || sync_p)) seq_err = ERR_SCHED_BARE;
                    else if (upd_p)         seq_err = ERR_NO_UPDATE;
        EV_LISTUPD: if (!upd_p) seq_err = ERR_UPD_BARE;
        EV_IRQ:     if (irq_p)  seq_err = ERR_IRQ_LOST;
        EV_ISR:     if (!irq_p) seq_err = ERR_ISR_BARE;
        default:    seq_err = ERR_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tick_p <= 1'b0;
      sync_p <= 1'b0;
      irq_p  <= 1'b0;
      upd_p  <= 1'b0;
    end else if (acc) begin
      unique case (code)
        EV_TICK:    tick_p <= 1'b1;
        EV_SCHED: begin
          tick_p <= 1'b0;
          sync_p <= 1'b0;
          upd_p  <= 1'b1;
        end
        EV_LISTUPD: upd_p  <= 1'b0;
        EV_IRQ:     irq_p  <= 1'b1;
        EV_ISR:     irq_p  <= 1'b0;
        EV_SEMBLK,
        EV_SEMWAKE: sync_p <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/prio_sched_guard.sv
module prio_sched_guard
  import sched_chk_pkg::*;
#(
  parameter int NTASK = 14,
  parameter int PW    = 3,
  localparam int TW   = $clog2(NTASK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_task,
  input  logic [PW-1:0] cfg_prio,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [2:0]    ev_code,
  input  logic [TW-1:0] ev_task,
  output logic          err_flag,
  output logic [3:0]    err_code
);

  localparam logic [NTASK-1:0] ONE_HOT0 = NTASK'(1);

  logic                        active;
  logic [NTASK-1:0][PW-1:0]    prio_q;
  logic [NTASK-1:0]            cfg_ok;
  logic [NTASK-1:0]            rdy_set, blk_set;
  logic [TW-1:0]               running;
  logic [TW-1:0]               pick;
  logic                        acc;
  ev_e                         code;
  logic                        t_rdy, t_blk;
  err_e                        task_err, seq_err, new_err;

  assign ev_ready = active;
  assign acc      = ev_valid && active;
  assign code     = ev_e'(ev_code);

  always_ff @(posedge clk) begin
    if (!rst_n)     active <= 1'b0;
    else if (start) active <= 1'b1;
  end

  // Priority table; slot 0 is the idle task, pinned to priority 0.
  for (genvar i = 0; i < NTASK; i++) begin : g_prio
    if (i == 0) begin : g_idle
      assign prio_q[i] = '0;
      assign cfg_ok[i] = 1'b1;
    end else begin : g_app
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prio_q[i] <= '0;
          cfg_ok[i] <= 1'b0;
        end else if (cfg_we && (cfg_task == TW'(i))) begin
          prio_q[i] <= cfg_prio;
          cfg_ok[i] <= 1'b1;
        end
      end
    end
  end

  assign t_rdy = |(rdy_set & (ONE_HOT0 << ev_task));
  assign t_blk = |(blk_set & (ONE_HOT0 << ev_task));

  // Set movements
  logic blk_move, wake_move;
  assign blk_move  = acc && (code == EV_SEMBLK) && (running != '0);
  assign wake_move = acc && (code == EV_SEMWAKE) && t_blk;

  task_set_store #(.N(NTASK), .TW(TW)) u_ready_set (
    .clk(clk), .rst_n(rst_n),
    .load(start), .load_val(cfg_ok),
    .set_en(wake_move), .set_idx(ev_task),
    .clr_en(blk_move),  .clr_idx(running),
    .present(rdy_set)
  );

  task_set_store #(.N(NTASK), .TW(TW)) u_blocked_set (
    .clk(clk), .rst_n(rst_n),
    .load(start), .load_val('0),
    .set_en(blk_move),  .set_idx(running),
    .clr_en(wake_move), .clr_idx(ev_task),
    .present(blk_set)
  );

  rr_prio_picker #(.N(NTASK), .TW(TW), .PW(PW)) u_picker (
    .ready(rdy_set), .prio(prio_q), .last(running), .pick(pick)
  );

  kernel_seq_watch u_seq (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .acc(acc), .code(code), .seq_err(seq_err)
  );

  // Task-identity checks for RUN and SCHED
  always_comb begin
    task_err = ERR_NONE;
    if (acc && ((code == EV_RUN) || (code == EV_SCHED))) begin
      if (t_blk)                                  task_err = ERR_BLK_RUNS;
      else if (!t_rdy)                            task_err = ERR_UNKNOWN;
      else if ((code == EV_SCHED) && (ev_task != pick))   task_err = ERR_NOT_TOP;
      else if ((code == EV_RUN) && (ev_task != running))  task_err = ERR_NOT_TOP;
    end
  end

  assign new_err = (task_err != ERR_NONE) ? task_err : seq_err;

  always_ff @(posedge clk) begin
    if (!rst_n || start)
      running <= '0;
    else if (acc && (code == EV_SCHED) && (t_rdy || t_blk))
      running <= ev_task;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_code <= ERR_NONE;
    end else if (!err_flag && (new_err != ERR_NONE)) begin
      err_flag <= 1'b1;
      err_code <= new_err;
    end
  end

endmodule

// File: rtl/prio_sched_guard_sva.sv
module prio_sched_guard_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic       err_flag,
  input logic [3:0] err_code
);

  assert_clean_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> (err_code == 4'd0));

  assert_ready_opens_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_ready) |-> $past(start));

  assert_ready_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> ev_ready);

  assert_no_error_without_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !(ev_valid && ev_ready)) |=> !err_flag);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_code_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> $stable(err_code));

  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> ((err_code >= 4'd1) && (err_code <= 4'd9)));

endmodule

bind prio_sched_guard prio_sched_guard_sva u_sva (.*);

// File: tb/prio_sched_guard_bench.sv
module prio_sched_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_task = '0;
  logic [2:0] cfg_prio = '0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [2:0] ev_code = '0;
  logic [3:0] ev_task = '0;
  logic       err_flag;
  logic [3:0] err_code;

  int total = 0;
  int fails = 0;
  int model = 0;
  int    exp_q[$];
  string req_q[$];
  logic  chk_due = 1'b0;

  always #10 clk = ~clk;

  prio_sched_guard u_prio_sched_guard (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_prio(cfg_prio),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code), .ev_task(ev_task),
    .err_flag(err_flag), .err_code(err_code)
  );

  task automatic check(int act, int expv, string req);
    total++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: one comparison per accepted event
  always @(posedge clk) chk_due <= ev_valid && ev_ready;

  always @(negedge clk) begin
    if (chk_due && exp_q.size() > 0) begin
      int    e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(int'(err_code), e, r);
      check(int'(err_flag), (e != 0) ? 1 : 0, r);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ev_valid = 1'b0; start = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model = 0;
  endtask

  task automatic cfg(int t, int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_task = 4'(t); cfg_prio = 3'(p);
  endtask

  task automatic go();
    @(negedge clk);
    cfg_we = 1'b0; ev_valid = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Driver: offer one event and push the expected latched code
  task automatic ev(int c, int t, int newc, string req);
    @(negedge clk);
    ev_valid = 1'b1; ev_code = 3'(c); ev_task = 4'(t);
    if (model == 0) model = newc;
    exp_q.push_back(model);
    req_q.push_back(req);
  endtask

  task automatic quiet();
    @(negedge clk);
    ev_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic std_cfg();
    cfg(1, 1); cfg(2, 3); cfg(3, 3); cfg(4, 2);
  endtask

  localparam int RUN = 0, TICK = 1, IRQ = 2, ISR = 3, SCHED = 4, UPD = 5, BLK = 6, WAKE = 7;

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    check(int'(err_flag), 0, "R1 flag");
    check(int'(err_code), 0, "R1 code");
    check(int'(ev_ready), 0, "R1 ready");

    // R2 events before start are dropped
    std_cfg();
    @(negedge clk); cfg_we = 1'b0;
    ev_valid = 1'b1; ev_code = 3'(SCHED); ev_task = 4'd9;
    repeat (2) @(negedge clk);
    ev_valid = 1'b0;
    check(int'(err_flag), 0, "R2 pre-start ignored");
    go();
    check(int'(ev_ready), 1, "R2 ready after start");

    // Main flow: R4, R5, R6, R7, R9, R11
    ev(TICK, 0, 0, "R8 tick");
    ev(SCHED, 2, 0, "R4 top pick");
    ev(UPD, 0, 0, "R10 update");
    ev(TICK, 0, 0, "R8 tick");
    ev(SCHED, 3, 0, "R5 rotate to 3");
    ev(UPD, 0, 0, "R10 update");
    ev(TICK, 0, 0, "R8 tick");
    ev(SCHED, 2, 0, "R5 rotate wraps to 2");
    ev(UPD, 0, 0, "R10 update");
    ev(RUN, 2, 0, "R7 running ok");
    ev(BLK, 0, 0, "R6 block 2");
    ev(SCHED, 3, 0, "R6 only 3 left");
    ev(UPD, 0, 0, "R10 update");
    ev(WAKE, 2, 0, "R6 wake 2");
    ev(SCHED, 2, 0, "R5 rotate after wake");
    ev(UPD, 0, 0, "R10 update");
    ev(BLK, 0, 0, "R6 block 2");
    ev(SCHED, 3, 0, "R6 pick 3");
    ev(UPD, 0, 0, "R10 update");
    ev(BLK, 0, 0, "R6 block 3");
    ev(SCHED, 4, 0, "R4 fall to prio 2");
    ev(UPD, 0, 0, "R10 update");
    ev(RUN, 4, 0, "R7 running 4");
    ev(IRQ, 0, 0, "R9 irq");
    ev(ISR, 0, 0, "R9 isr");
    ev(RUN, 2, 1, "R7 blocked task runs");
    ev(TICK, 0, 0, "R11 sticky");
    ev(TICK, 0, 4, "R11 first error kept");
    quiet();

    // R4 lower-priority choice
    do_reset(); std_cfg(); go();
    ev(TICK, 0, 0, "R8 tick");
    ev(SCHED, 1, 3, "R4 not highest");
    quiet();

    // R7 unconfigured task
    do_reset(); std_cfg(); go();
    ev(TICK, 0, 0, "R8 tick");
    ev(SCHED, 5, 2, "R7 unknown task");
    quiet();

    // R3 ready but not running
    do_reset(); std_cfg(); go();
    ev(RUN, 0, 0, "R3 idle running");
    ev(RUN, 1, 3, "R3 ready not running");
    quiet();

    // R8 lost tick, bare schedule
    do_reset(); std_cfg(); go();
    ev(TICK, 0, 0, "R8 tick");
    ev(TICK, 0, 4, "R8 tick lost");
    quiet();
    do_reset(); std_cfg(); go();
    ev(SCHED, 2, 5, "R8 sched without cause");
    quiet();

    // R11 lowest code in one event
    do_reset(); std_cfg(); go();
    ev(SCHED, 1, 3, "R11 lowest code wins");
    quiet();

    // R9 irq pairing
    do_reset(); std_cfg(); go();
    ev(IRQ, 0, 0, "R9 irq");
    ev(IRQ, 0, 6, "R9 irq not handled");
    quiet();
    do_reset(); std_cfg(); go();
    ev(ISR, 0, 7, "R9 isr without irq");
    quiet();

    // R10 update pairing
    do_reset(); std_cfg(); go();
    ev(TICK, 0, 0, "R8 tick");
    ev(SCHED, 2, 0, "R4 top pick");
    ev(TICK, 0, 0, "R8 tick");
    ev(SCHED, 3, 8, "R10 sched without update");
    quiet();
    do_reset(); std_cfg(); go();
    ev(UPD, 0, 9, "R10 update without sched");
    quiet();

    // R12 idle priority pinned, idle never blocks
    do_reset();
    cfg(0, 7); cfg(1, 1); go();
    ev(BLK, 0, 0, "R6 idle block ignored");
    ev(RUN, 0, 0, "R12 idle still ready");
    ev(SCHED, 1, 0, "R12 idle below task 1");
    ev(UPD, 0, 0, "R10 update");
    quiet();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule